// File: doc/BRIEF.md
# Wishbone to byte register bridge

This block is a Wishbone classic slave. A 32-bit bus master uses it to read and write a small bank of 8-bit control registers. Each word access covers four consecutive byte registers. A byte is written only when its lane is selected, and only the bits that a per-register write mask allows can change. The bank answers at a fixed base address. Any access whose upper address bits do not match that base, and any byte beyond the implemented registers, reads as zero and drops writes.

The acknowledge reports the register contents as they stood when the request was accepted. For a write, that is the value before the write. Write data is committed a few cycles after the request is accepted. One designated word, the GPIO data word, commits much later than the others, to model a value that is shifted out serially. The bridge accepts nothing new until a pending write has committed, so a read that follows a write always sees the new data. An enable input lets the surrounding logic hold off acceptance of requests.

Top module: `wb_byte_regs`

## Requirements
- R1: The word index is taken from address bits 11:2, and bits 1:0 are ignored. Byte offset 4*w+0 is carried in data bits 31:24, 4*w+1 in bits 23:16, 4*w+2 in bits 15:8 and 4*w+3 in bits 7:0.
- R2: Select bit 3 gates bits 31:24 and select bit 0 gates bits 7:0. A byte whose select bit is 0 keeps its value.
- R3: An access hits the bank only when address bits 31:13 equal those bits of BASE_ADDR (default 0x2600_0000). Bit 12 is ignored, so an address with bit 12 set aliases to the same word. On a miss, reads return 0 and writes change nothing.
- R4: Byte offsets at or above NUM_REGS (default 14) read as 0 and ignore writes.
- R5: A write changes only the bits that are set in the register's mask. The default masks are: offset 0 = 0xFF, offset 1 = 0x0F, offset 2 = 0x00, offset 3 = 0x3C, and offsets 4 to 13 = 0xFF. Bits outside the mask keep their value.
- R6: The acknowledge is a single-cycle pulse, raised in the cycle after the edge that accepts the request. During that pulse the read data holds the word as it stood at acceptance, which for a write is the value before the write.
- R7: An ordinary write commits on the second clock edge after acceptance. The bridge accepts no request while the acknowledge is high or while a write is pending. A request presented in the cycle of a write acknowledge is acknowledged 3 cycles later. A read presented in the cycle of a read acknowledge is acknowledged 2 cycles later.
- R8: A write to the GPIO data word (byte offsets 12 to 15, word address 0x0C) commits on the ninth edge after acceptance. A request presented in the cycle of its acknowledge is acknowledged 10 cycles later.
- R9: While take_en is low, no request is accepted and no acknowledge is raised. A held request is accepted on the first edge where take_en is high.
- R10: A synchronous reset clears all registers, the acknowledge and the read data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Request strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_sel_i | input | 4 | Byte lane selects |
| wb_adr_i | input | 32 | Byte address |
| wb_dat_i | input | 32 | Write data |
| take_en | input | 1 | When low, requests are held off |
| wb_dat_o | output | 32 | Read data, valid with the acknowledge |
| wb_ack_o | output | 1 | One-cycle acknowledge |

## Verification
On an idle bus, the acknowledge for a request comes one edge after the request is presented. A request chained from the previous acknowledge is acknowledged 2 edges later after a read, 3 edges later after an ordinary write, and 10 edges later after a GPIO-word write. Every bus call in the bench counts edges, sampling one time unit after each rising edge, and compares that count with the figure the requirement gives. The data returned with each acknowledge is compared with a byte model that the bench updates only when the write commits. Because every write is followed by a read, a commit that is late, missing or wrongly masked shows up as a wrong count or a wrong word.

// File: rtl/wb_byte_regs.sv
module wb_byte_regs #(
  parameter logic [31:0] BASE_ADDR = 32'h2600_0000,
  parameter int NUM_REGS = 14,
  parameter logic [NUM_REGS*8-1:0] RW_MASK = 112'hFFFF_FFFF_FFFF_FFFF_FFFF_3C00_0FFF,
  parameter int GPIO_OFS = 12,
  parameter int WR_LAT = 2,
  parameter int GPIO_LAT = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic [3:0]  wb_sel_i,
  input  logic [31:0] wb_adr_i,
  input  logic [31:0] wb_dat_i,
  input  logic        take_en,
  output logic [31:0] wb_dat_o,
  output logic        wb_ack_o
);
  localparam int MAXL = (WR_LAT > GPIO_LAT) ? WR_LAT : GPIO_LAT;
  localparam int CW = $clog2(MAXL + 1);
  localparam logic [18:0] BASE_HI = BASE_ADDR[31:13];
  localparam logic [9:0] GPIO_WORD = 10'(GPIO_OFS / 4);

  logic [7:0]    regs [NUM_REGS];
  logic [CW-1:0] wait_cnt;
  logic [9:0]    word_q;
  logic [3:0]    sel_q;
  logic [31:0]   dat_q;
  logic          hit_q;
  logic [31:0]   rd_word;

  wire hit    = (wb_adr_i[31:13] == BASE_HI);
  wire accept = wb_cyc_i & wb_stb_i & take_en & ~wb_ack_o & (wait_cnt == '0);
  wire late   = (wb_adr_i[11:2] == GPIO_WORD);

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (hit && wb_adr_i[11:2] == 10'(r / 4))
        rd_word[8*(3 - (r % 4)) +: 8] = regs[r];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
      wait_cnt <= '0;
      word_q   <= '0;
      sel_q    <= '0;
      dat_q    <= '0;
      hit_q    <= 1'b0;
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack_o <= accept;
      if (accept) begin
        wb_dat_o <= rd_word;
        word_q   <= wb_adr_i[11:2];
        sel_q    <= wb_sel_i;
        dat_q    <= wb_dat_i;
        hit_q    <= hit;
        if (wb_we_i) wait_cnt <= late ? CW'(GPIO_LAT) : CW'(WR_LAT);
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
        if (wait_cnt == CW'(1)) begin
          for (int r = 0; r < NUM_REGS; r++)
            if (hit_q && word_q == 10'(r / 4) && sel_q[3 - (r % 4)])
              regs[r] <= (regs[r] & ~RW_MASK[8*r +: 8]) |
                         (dat_q[8*(3 - (r % 4)) +: 8] & RW_MASK[8*r +: 8]);
        end
      end
    end
  end
endmodule

// File: rtl/wb_byte_regs_chk.sv
module wb_byte_regs_chk #(
  parameter logic [31:0] BASE_ADDR = 32'h2600_0000
) (
  input logic        clk,
  input logic        rst,
  input logic        wb_cyc_i,
  input logic        wb_stb_i,
  input logic        take_en,
  input logic [31:0] wb_adr_i,
  input logic [31:0] wb_dat_o,
  input logic        wb_ack_o
);
  localparam logic [18:0] BASE_HI = BASE_ADDR[31:13];

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst) wb_ack_o |=> !wb_ack_o); // R6
  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i && take_en)); // R6
  AST_HELD_NO_ACK: assert property (@(posedge clk) disable iff (rst) !take_en |=> !wb_ack_o); // R9
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wb_ack_o && $past(wb_adr_i[31:13]) != BASE_HI) |-> wb_dat_o == 32'h0); // R3
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!wb_ack_o && wb_dat_o == 32'h0)); // R10
endmodule

bind wb_byte_regs wb_byte_regs_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst(rst), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .take_en(take_en),
  .wb_adr_i(wb_adr_i), .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o)
);

// File: tb/sim_wb_byte_regs.sv
`timescale 1ns/1ps
module sim_wb_byte_regs;
  localparam logic [31:0] BASE = 32'h2600_0000;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cyc, stb, we, ten, ack;
  logic [3:0] sel;
  logic [31:0] adr, din, dout;

  wb_byte_regs u0 (.clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_sel_i(sel), .wb_adr_i(adr), .wb_dat_i(din), .take_en(ten),
    .wb_dat_o(dout), .wb_ack_o(ack));

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [16];
  logic [7:0] msk [16];

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input int w);
    logic [31:0] v = '0;
    for (int i = 0; i < 4; i++)
      if (w * 4 + i < 14) v[8*(3-i) +: 8] = mdl[w*4+i];
    return v;
  endfunction

  task automatic mwrite(input int w, input logic [3:0] s, input logic [31:0] d);
    for (int i = 0; i < 4; i++) begin
      int b = w * 4 + i;
      if (b < 14 && s[3-i]) mdl[b] = (mdl[b] & ~msk[b]) | (d[8*(3-i) +: 8] & msk[b]);
    end
  endtask

  task automatic bus(input logic w, input logic [31:0] a, input logic [3:0] s,
                     input logic [31:0] d, output logic [31:0] q, output int lat);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; sel = s; din = d;
    lat = 0;
    do begin
      @(posedge clk); #1; lat++;
    end while (!ack && lat < 40);
    q = dout;
    if (!ack) chk("bus timeout", 32'h0, 32'h1);
    @(negedge clk);
  endtask

  task automatic idle();
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] wa(input int w);
    return BASE + 32'(w * 4);
  endfunction

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] q, d;
    int lat;
    for (int i = 0; i < 16; i++) begin mdl[i] = 8'h00; msk[i] = (i < 14) ? 8'hFF : 8'h00; end
    msk[1] = 8'h0F; msk[2] = 8'h00; msk[3] = 8'h3C;
    rst = 1'b1; cyc = 0; stb = 0; we = 0; sel = 0; adr = 0; din = 0; ten = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 ack in reset", {31'h0, ack}, 32'h0);
    chk("R10 data in reset", dout, 32'h0);
    @(negedge clk); rst = 1'b0;

    for (int w = 0; w < 5; w++) begin
      bus(1'b0, wa(w), 4'hF, 32'h0, q, lat);
      chk("R10 R4 reset contents", q, 32'h0);
      idle();
    end

    for (int w = 0; w < 5; w++) begin
      bus(1'b0, wa(w), 4'hF, 32'h0, q, lat);
      chk("R6 idle ack latency", 32'(lat), 32'd1);
      d = 32'hFFFF_FFFF - 32'(w * 32'h0101_0101);
      bus(1'b1, wa(w), 4'hF, d, q, lat);
      chk("R6 write returns old", q, mread(w));
      chk("R7 chained after read", 32'(lat), 32'd2);
      mwrite(w, 4'hF, d);
      bus(1'b0, wa(w), 4'hF, 32'h0, q, lat);
      chk("R1 R4 R5 readback", q, mread(w));
      chk(w == 3 ? "R8 gpio commit latency" : "R7 write commit latency", 32'(lat), w == 3 ? 32'd10 : 32'd3);
      idle();
    end

    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 16; s++) begin
        d = 32'h1234_5678 ^ (32'(s) * 32'h0F1E_2D3C) ^ 32'(w * 32'h5A5A_0000);
        bus(1'b1, wa(w) + 32'(s % 4), 4'(s), d, q, lat);
        chk("R6 old value on write", q, mread(w));
        mwrite(w, 4'(s), d);
        bus(1'b0, wa(w), 4'hF, 32'h0, q, lat);
        chk("R2 R1 R5 lane gated write", q, mread(w));
        idle();
      end

    bus(1'b1, wa(1) | 32'h0000_2000, 4'hF, 32'h0BAD_0BAD, q, lat);
    chk("R3 miss write ack data", q, 32'h0);
    bus(1'b0, wa(1), 4'hF, 32'h0, q, lat);
    chk("R3 miss write ignored", q, mread(1));
    bus(1'b0, wa(1) ^ 32'h8000_0000, 4'hF, 32'h0, q, lat);
    chk("R3 miss read zero", q, 32'h0);
    bus(1'b1, wa(1) | 32'h0000_1000, 4'hF, 32'hC0DE_F00D, q, lat);
    mwrite(1, 4'hF, 32'hC0DE_F00D);
    bus(1'b0, wa(1), 4'hF, 32'h0, q, lat);
    chk("R3 bit12 alias", q, mread(1));
    bus(1'b1, wa(4), 4'hF, 32'hFFFF_FFFF, q, lat);
    bus(1'b0, wa(4), 4'hF, 32'h0, q, lat);
    chk("R4 unimplemented word", q, 32'h0);
    idle();

    ten = 1'b0;
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = wa(2); sel = 4'hF;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      chk("R9 no ack while held", {31'h0, ack}, 32'h0);
    end
    @(negedge clk); ten = 1'b1;
    bus(1'b0, wa(2), 4'hF, 32'h0, q, lat);
    chk("R9 release latency", 32'(lat), 32'd1);
    chk("R9 release data", q, mread(2));
    idle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule